// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a 10-bit successive-approximation converter. Firmware requests a conversion with a start pulse. The sequencer can wait for a programmable number of acquisition periods while the holding capacitor tracks the input. It then disconnects the capacitor and resolves the code, most significant bit first. For each bit it drives a trial code to an external DAC and reads back a comparator decision. All sequencing advances on a one-cycle conversion-clock enable, `tadEn`, which marks the end of each conversion period (TAD).

When a conversion completes, the result register loads, the busy indication clears and a sticky done flag is raised. Firmware clears that flag with `irqClr`. Firmware may also abort. An abort during conversion stores the partially resolved code without raising the flag. An abort during acquisition simply returns the block to idle. Every completed or aborted conversion is followed by a fixed two-period recovery gap. In continuous mode the next conversion then starts by itself, with no new start command.

Top module: `sar_seq`

## Requirements
- R1: A conversion occupies 11 TAD periods. In the first ten, bits 9 down to 0 are trialled one per period, with trial code = resolved bits OR the candidate bit, so the first trial code is 10'h200. The eleventh period transfers the result.
- R2: A candidate bit is kept only when `cmpHigh` is 1, meaning the input is at or above the DAC level. With an ideal comparator the result therefore equals the input code.
- R3: The acquisition length, in TAD periods, follows `acqSel`: 0→0, 1→2, 2→4, 3→6, 4→8, 5→12, 6→16, 7→20. With 0, conversion begins at the TAD edge that accepts the start. `busy` is high for acquisition plus 11 TAD edges.
- R4: `holdDisc` is 1 (capacitor disconnected) for exactly the 11 conversion periods and 0 otherwise.
- R5: On normal completion, `busy` falls, `result` loads the code and `doneFlag` sets. `doneFlag` stays set until an `irqClr` pulse clears it.
- R6: An abort during conversion ends it at the next TAD edge. Bits already resolved are kept, unresolved bits read 0, and `doneFlag` is not set.
- R7: After completion or abort, a 2-TAD recovery gap follows. A start issued during the gap is ignored.
- R8: With `contMode` = 1 at the end of the gap, the next conversion starts automatically, and `busy` is low for exactly 2 TAD edges between conversions.
- R9: Start and abort requests are held until the next TAD edge. State changes only on TAD edges, so `busy` does not rise before one.
- R10: An abort during acquisition returns the block to idle. `result` is left unchanged and `doneFlag` stays clear.
- R11: After reset, `busy`, `holdDisc`, `doneFlag`, `result` and `trialCode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tadEn | input | 1 | One-cycle pulse ending each TAD period |
| startCmd | input | 1 | Start request pulse |
| abortCmd | input | 1 | Abort request pulse |
| acqSel | input | 3 | Acquisition-time select |
| contMode | input | 1 | Continuous conversion enable |
| irqClr | input | 1 | Clears the done flag |
| cmpHigh | input | 1 | Comparator: input at or above DAC level |
| busy | output | 1 | Acquisition or conversion in progress |
| holdDisc | output | 1 | Holding capacitor disconnected |
| trialCode | output | 10 | Code driven to the DAC |
| result | output | 10 | Result register |
| doneFlag | output | 1 | Conversion-done interrupt flag |

## Verification
The assertions assume that `tadEn` is a single-cycle pulse separated by idle cycles, and that `cmpHigh` settles combinationally from `trialCode` before each TAD edge. They also assume that the command pulses are one clock wide. The bench produces `tadEn` from a divide-by-four counter, pulses commands for one cycle on the falling clock edge, and models an ideal comparator as an unsigned compare of a held input code against `trialCode`. Its abort timing is chosen by counting TAD edges after `holdDisc` rises, so the number of resolved bits is known in advance.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_GAP
  } seqState_e;

  typedef struct packed {
    logic startConv;
    logic stepBit;
    logic loadRes;
    logic setIrq;
  } dpStrobe_t;

  function automatic int acqTads(input logic [2:0] sel);
    if (sel <= 3'd4) return 2 * int'(sel);
    else             return 4 * int'(sel) - 8;
  endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int W       = 10,
  parameter int GAP_TAD = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tadEn,
  input  logic       startCmd,
  input  logic       abortCmd,
  input  logic [2:0] acqSel,
  input  logic       contMode,
  output dpStrobe_t  strb,
  output logic       busy,
  output logic       holdDisc
);

  localparam int CNT_W = $clog2(acqTads(3'd7) + W + GAP_TAD + 2);

  seqState_e        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             startPend, abortPend;
  logic             startSeen, abortSeen;
  logic             launchNow;
  logic [CNT_W-1:0] acqLen;

  assign startSeen = startPend | startCmd;
  assign abortSeen = abortPend | abortCmd;
  assign acqLen    = CNT_W'(acqTads(acqSel));

  assign launchNow = ((state == ST_IDLE) && startSeen) ||
                     ((state == ST_GAP) && (cnt == CNT_W'(1)) && contMode);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    strb      = '0;
    if (tadEn) begin
      unique case (state)
        ST_IDLE, ST_GAP: begin
          if (launchNow) begin
            if (acqLen == '0) begin
              stateNext      = ST_CONV;
              cntNext        = '0;
              strb.startConv = 1'b1;
            end else begin
              stateNext = ST_ACQ;
              cntNext   = acqLen;
            end
          end else if (state == ST_GAP) begin
            if (cnt == CNT_W'(1)) stateNext = ST_IDLE;
            else                  cntNext   = cnt - 1'b1;
          end
        end
        ST_ACQ: begin
          if (abortSeen) begin
            stateNext = ST_IDLE;
          end else if (cnt == CNT_W'(1)) begin
            stateNext      = ST_CONV;
            cntNext        = '0;
            strb.startConv = 1'b1;
          end else begin
            cntNext = cnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (abortSeen || cnt == CNT_W'(W)) begin
            stateNext    = ST_GAP;
            cntNext      = CNT_W'(GAP_TAD);
            strb.loadRes = 1'b1;
            strb.setIrq  = !abortSeen;
          end else begin
            cntNext      = cnt + 1'b1;
            strb.stepBit = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      startPend <= 1'b0;
      abortPend <= 1'b0;
    end else begin
      state     <= stateNext;
      cnt       <= cntNext;
      startPend <= tadEn ? 1'b0 : startSeen;
      abortPend <= tadEn ? 1'b0 : abortSeen;
    end
  end

  assign busy     = (state == ST_ACQ) || (state == ST_CONV);
  assign holdDisc = (state == ST_CONV);

  // R9: the sequence only moves on TAD edges
  a_r9_tad_only: assert property (@(posedge clk) disable iff (!rstN)
    !tadEn |=> $stable(state));

  // R7: every end of conversion enters the recovery gap
  a_r7_gap_after_end: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRes |=> (state == ST_GAP));

  // R4: the capacitor is only disconnected while a conversion is owned
  a_r4_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    holdDisc |-> busy);

  // R6: an abort in conversion never raises the flag
  a_r6_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (tadEn && abortSeen && state == ST_CONV) |-> !strb.setIrq);

endmodule

// File: rtl/sar_seq_dp.sv
module sar_seq_dp
  import sar_seq_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpStrobe_t    strb,
  input  logic         cmpHigh,
  input  logic         irqClr,
  output logic [W-1:0] trialCode,
  output logic [W-1:0] result,
  output logic         doneFlag
);

  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code;
  logic [W-1:0] mask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      code     <= '0;
      mask     <= '0;
      result   <= '0;
      doneFlag <= 1'b0;
    end else begin
      if (strb.startConv) begin
        code <= '0;
        mask <= MSB_MASK;
      end else if (strb.stepBit) begin
        if (cmpHigh) code <= code | mask;
        mask <= mask >> 1;
      end else if (strb.loadRes) begin
        mask <= '0;
      end
      if (strb.loadRes) result <= code;
      if (strb.setIrq)       doneFlag <= 1'b1;
      else if (irqClr)       doneFlag <= 1'b0;
    end
  end

  assign trialCode = code | mask;

  // R1: at most one candidate bit is on trial
  a_r1_one_candidate: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mask));

  // R5: completion raises the done flag
  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.setIrq |=> doneFlag);

  // R6: the result register captures the resolved bits at the end
  a_r6_load_code: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRes |=> (result == $past(code)));

endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int W       = 10,
  parameter int GAP_TAD = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tadEn,
  input  logic         startCmd,
  input  logic         abortCmd,
  input  logic [2:0]   acqSel,
  input  logic         contMode,
  input  logic         irqClr,
  input  logic         cmpHigh,
  output logic         busy,
  output logic         holdDisc,
  output logic [W-1:0] trialCode,
  output logic [W-1:0] result,
  output logic         doneFlag
);

  dpStrobe_t strb;

  sar_seq_ctrl #(.W(W), .GAP_TAD(GAP_TAD)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tadEn    (tadEn),
    .startCmd (startCmd),
    .abortCmd (abortCmd),
    .acqSel   (acqSel),
    .contMode (contMode),
    .strb     (strb),
    .busy     (busy),
    .holdDisc (holdDisc)
  );

  sar_seq_dp #(.W(W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmpHigh   (cmpHigh),
    .irqClr    (irqClr),
    .trialCode (trialCode),
    .result    (result),
    .doneFlag  (doneFlag)
  );

endmodule

// File: tb/test_sar_seq.sv
module test_sar_seq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tadEn;
  logic       startCmd = 1'b0;
  logic       abortCmd = 1'b0;
  logic [2:0] acqSel = 3'd0;
  logic       contMode = 1'b0;
  logic       irqClr = 1'b0;
  logic       cmpHigh;
  logic       busy, holdDisc, doneFlag;
  logic [9:0] trialCode, result;
  logic [9:0] vin = 10'd0;
  logic [1:0] divCnt;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end
  assign tadEn   = (divCnt == 2'd3);
  assign cmpHigh = (vin >= trialCode);

  sar_seq i_sar_seq (
    .clk(clk), .rstN(rstN), .tadEn(tadEn), .startCmd(startCmd),
    .abortCmd(abortCmd), .acqSel(acqSel), .contMode(contMode),
    .irqClr(irqClr), .cmpHigh(cmpHigh), .busy(busy), .holdDisc(holdDisc),
    .trialCode(trialCode), .result(result), .doneFlag(doneFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic clearFlag();
    pulse(irqClr);
  endtask

  // Runs one conversion from a start pulse until busy falls; counts TAD edges.
  task automatic runConv(input logic [9:0] v, input logic [2:0] sel,
                         output int busyTads, output int holdTads, output int firstTrial);
    bit seen = 0;
    bit gotTrial = 0;
    busyTads = 0; holdTads = 0; firstTrial = -1;
    vin = v; acqSel = sel;
    pulse(startCmd);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (busy) seen = 1;
      if (holdDisc && !gotTrial) begin firstTrial = int'(trialCode); gotTrial = 1; end
      if (tadEn) begin
        if (busy) busyTads++;
        if (holdDisc) holdTads++;
      end
      if (seen && !busy) break;
    end
  endtask

  task automatic testReset();
    check("R11 busy", int'(busy), 0);
    check("R11 holdDisc", int'(holdDisc), 0);
    check("R11 doneFlag", int'(doneFlag), 0);
    check("R11 result", int'(result), 0);
    check("R11 trialCode", int'(trialCode), 0);
  endtask

  task automatic testNormal(input logic [9:0] v, input logic [2:0] sel, input int acqLen);
    int bt, ht, ft;
    clearFlag();
    runConv(v, sel, bt, ht, ft);
    check("R1 first trial code", ft, 10'h200);
    check("R2 result", int'(result), int'(v));
    check("R3 busy TAD count", bt, acqLen + 11);
    check("R4 hold TAD count", ht, 11);
    check("R5 doneFlag set", int'(doneFlag), 1);
    check("R4 hold released", int'(holdDisc), 0);
    repeat (12) @(negedge clk);
  endtask

  task automatic testIrqClear();
    check("R5 flag sticky", int'(doneFlag), 1);
    clearFlag();
    @(negedge clk);
    check("R5 flag cleared", int'(doneFlag), 0);
  endtask

  task automatic testAbortConv(input logic [9:0] v, input int k);
    logic [9:0] keep;
    int n = 0;
    clearFlag();
    vin = v; acqSel = 3'd0;
    pulse(startCmd);
    while (!holdDisc) @(negedge clk);
    while (n < k) begin
      if (tadEn) n++;
      @(negedge clk);
    end
    pulse(abortCmd);
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    keep = ~(10'h3FF >> k);
    check("R6 partial result", int'(result), int'(v & keep));
    check("R6 no doneFlag", int'(doneFlag), 0);
    check("R6 busy cleared", int'(busy), 0);
    repeat (12) @(negedge clk);
  endtask

  task automatic testGapIgnore();
    int bt, ht, ft;
    logic [9:0] prev;
    runConv(10'h155, 3'd0, bt, ht, ft);
    prev = result;
    pulse(startCmd);
    repeat (32) @(negedge clk);
    check("R7 start in gap ignored", int'(busy), 0);
    check("R7 result kept", int'(result), int'(prev));
  endtask

  task automatic testStartHeld();
    while (!tadEn) @(negedge clk);
    @(negedge clk);
    pulse(startCmd);
    check("R9 no busy before TAD edge", int'(busy), 0);
    for (int i = 0; i < 10 && !busy; i++) @(negedge clk);
    check("R9 held start accepted", int'(busy), 1);
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic testContinuous();
    int bt, ht, ft, low;
    clearFlag();
    contMode = 1'b1;
    runConv(10'h0F3, 3'd0, bt, ht, ft);
    check("R8 first result", int'(result), 10'h0F3);
    vin = 10'h31C;
    low = 0;
    for (int i = 0; i < 200 && !busy; i++) begin
      if (tadEn) low++;
      @(negedge clk);
    end
    check("R8 auto restart", int'(busy), 1);
    check("R7 gap length", low, 2);
    contMode = 1'b0;
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    check("R8 second result", int'(result), 10'h31C);
    repeat (32) @(negedge clk);
    check("R8 stops when disabled", int'(busy), 0);
  endtask

  task automatic testAbortAcq();
    logic [9:0] prev;
    bit sawHold = 0;
    int n = 0;
    clearFlag();
    prev = result;
    vin = 10'h2AA; acqSel = 3'd7;
    pulse(startCmd);
    while (n < 3) begin
      if (tadEn && busy) n++;
      @(negedge clk);
    end
    pulse(abortCmd);
    for (int i = 0; i < 100 && busy; i++) begin
      if (holdDisc) sawHold = 1;
      @(negedge clk);
    end
    check("R10 back to idle", int'(busy), 0);
    check("R10 result unchanged", int'(result), int'(prev));
    check("R10 no doneFlag", int'(doneFlag), 0);
    check("R10 no conversion", int'(sawHold), 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testNormal(10'h2A5, 3'd0, 0);
    testIrqClear();
    testNormal(10'h3FF, 3'd2, 4);
    testNormal(10'h000, 3'd7, 20);
    testNormal(10'h001, 3'd5, 12);
    testNormal(10'h200, 3'd1, 2);
    testAbortConv(10'h3B7, 4);
    testAbortConv(10'h1FF, 1);
    testGapIgnore();
    testStartHeld();
    testContinuous();
    testAbortAcq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule